// File: doc/BRIEF.md
# Serial Boot Image Loader

This block copies a fixed-size boot image from a serial byte stream into on-chip SRAM and then tells the processor to start running it. After power-on reset is released it waits in standby and does nothing. It leaves standby only when the wake input rises from low to high. A wake input that is already high when reset is released does not count as a rise.

Once woken, it takes each byte that the UART receiver reports through its byte-valid strobe. It writes the byte into SRAM through a single-cycle write port, using consecutive addresses that start at the SRAM base. When the last byte of the image has been written, it raises a one-cycle start-execution pulse that carries the SRAM base address. After that pulse it stays idle until the next power-on reset.

The UART receiver, the SRAM array and the processor are outside this block.

Top module: `bootld_top`

## Requirements
- R1: While power-on reset is active, and after it is released until a wake rise arrives, `memWrEn` and `startExec` stay low.
- R2: Loading begins only after a low-to-high transition of `wakeIn` is seen on a clock edge. A `wakeIn` that is already high when reset is released does not start loading.
- R3: Each accepted byte is written in the same cycle that `rxValid` is high. `memWrData` equals `rxData`, and `memAddr` equals BASE_ADDR plus the number of bytes accepted before it. With default parameters the addresses run from 0 to 2047 in arrival order.
- R4: Exactly IMAGE_BYTES bytes (2048 by default) are written in one load. No write happens after the last one.
- R5: `startExec` is high for exactly one cycle. That cycle immediately follows the cycle in which the final byte was written. While it is high, `startAddr` equals BASE_ADDR (0 by default).
- R6: A byte strobe that arrives in standby, in the same cycle as the wake rise, or after the image is complete produces no write.
- R7: After the start pulse the block stays terminal. Further wake rises and bytes cause no write and no second start pulse until power-on reset is asserted again.
- R8: Asserting `porN` low at any point, including in the middle of a load, returns the block to standby with the byte count cleared. The next load after reset again begins at BASE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| wakeIn | input | 1 | Wake request; its rising edge starts the load |
| rxValid | input | 1 | One-cycle strobe from the UART receiver marking a received byte |
| rxData | input | DATA_W | Received byte |
| memWrEn | output | 1 | SRAM write enable |
| memAddr | output | ADDR_W | SRAM write address |
| memWrData | output | DATA_W | SRAM write data |
| startExec | output | 1 | One-cycle pulse: begin execution from the SRAM base |
| startAddr | output | ADDR_W | Execution start address (BASE_ADDR) |

## Verification
The write port is combinational from `rxValid` once loading is under way. The bench therefore drives each byte just after a rising edge and reads `memWrEn`, `memAddr` and `memWrData` at the falling edge of the same cycle. A wake rise changes the state one edge after it is driven, so a byte driven together with that rise falls in a standby cycle and must not be written. `startExec` is due exactly one cycle after the final write. The bench timestamps both events with a cycle counter and compares them, and it also counts every start pulse and every write, including those outside a load.

// File: rtl/bootld_pkg.sv
package bootld_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_LOAD    = 2'd1,
    ST_FIRE    = 2'd2,
    ST_HALT    = 2'd3
  } ldState_t;

  // Strobes from control to the address/data path
  typedef struct packed {
    logic clearCnt;
    logic incCnt;
  } ldStrobe_t;

endpackage

// File: rtl/bootld_ctrl.sv
module bootld_ctrl
  import bootld_pkg::*;
(
  input  logic      clk,
  input  logic      porN,
  input  logic      wakeIn,
  input  logic      rxValid,
  input  logic      lastByte,
  output ldStrobe_t strobe,
  output logic      startExec
);

  ldState_t stateQ, stateD;
  logic     wakeQ;
  logic     wakeRise;

  // wakeQ resets high so a level already high at release is not a rise
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) wakeQ <= 1'b1;
    else       wakeQ <= wakeIn;
  end

  assign wakeRise = wakeIn && !wakeQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_STANDBY: if (wakeRise) stateD = ST_LOAD;
      ST_LOAD:    if (rxValid && lastByte) stateD = ST_FIRE;
      ST_FIRE:    stateD = ST_HALT;
      ST_HALT:    stateD = ST_HALT;
      default:    stateD = ST_STANDBY;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) stateQ <= ST_STANDBY;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.clearCnt = (stateQ == ST_STANDBY);
    strobe.incCnt   = (stateQ == ST_LOAD) && rxValid;
  end

  assign startExec = (stateQ == ST_FIRE);

  AST_LOAD_NEEDS_RISE: assert property (@(posedge clk) disable iff (!porN)
    (stateQ == ST_LOAD && $past(stateQ) == ST_STANDBY) |-> ($past(wakeIn) && !$past(wakeQ))); // R2

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!porN)
    (stateQ == ST_HALT) |=> (stateQ == ST_HALT)); // R7

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!porN)
    startExec |=> !startExec); // R5

endmodule

// File: rtl/bootld_dp.sv
module bootld_dp
  import bootld_pkg::*;
#(
  parameter int IMAGE_BYTES = 2048,
  parameter int DATA_W      = 8,
  parameter int BASE_ADDR   = 0,
  localparam int ADDR_W     = $clog2(IMAGE_BYTES)
) (
  input  logic              clk,
  input  logic              porN,
  input  ldStrobe_t         strobe,
  input  logic [DATA_W-1:0] rxData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              lastByte
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(IMAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] cntQ;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                cntQ <= '0;
    else if (strobe.clearCnt) cntQ <= '0;
    else if (strobe.incCnt)   cntQ <= cntQ + 1'b1;
  end

  assign lastByte  = (cntQ == LAST_IDX);
  assign memWrEn   = strobe.incCnt;
  assign memAddr   = BASE + cntQ;
  assign memWrData = rxData;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!porN)
    memWrEn |=> (memAddr == $past(memAddr) + 1'b1)); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (!strobe.incCnt && !strobe.clearCnt) |=> $stable(memAddr)); // R3

  AST_STANDBY_AT_BASE: assert property (@(posedge clk) disable iff (!porN)
    strobe.clearCnt |=> (memAddr == BASE)); // R8

endmodule

// File: rtl/bootld_top.sv
module bootld_top
  import bootld_pkg::*;
#(
  parameter int IMAGE_BYTES = 2048,
  parameter int DATA_W      = 8,
  parameter int BASE_ADDR   = 0,
  localparam int ADDR_W     = $clog2(IMAGE_BYTES)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              wakeIn,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              startExec,
  output logic [ADDR_W-1:0] startAddr
);

  ldStrobe_t strobe;
  logic      lastByte;

  bootld_ctrl ctrl_i (
    .clk       (clk),
    .porN      (porN),
    .wakeIn    (wakeIn),
    .rxValid   (rxValid),
    .lastByte  (lastByte),
    .strobe    (strobe),
    .startExec (startExec)
  );

  bootld_dp #(
    .IMAGE_BYTES (IMAGE_BYTES),
    .DATA_W      (DATA_W),
    .BASE_ADDR   (BASE_ADDR)
  ) dp_i (
    .clk       (clk),
    .porN      (porN),
    .strobe    (strobe),
    .rxData    (rxData),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .lastByte  (lastByte)
  );

  assign startAddr = ADDR_W'(BASE_ADDR);

  AST_START_AFTER_LAST: assert property (@(posedge clk) disable iff (!porN)
    $rose(startExec) |-> ($past(memWrEn) &&
      $past(memAddr) == ADDR_W'(BASE_ADDR + IMAGE_BYTES - 1))); // R5

  AST_NO_WRITE_AT_START: assert property (@(posedge clk) disable iff (!porN)
    startExec |-> !memWrEn); // R4

  AST_NO_START_WHILE_WRITING: assert property (@(posedge clk) disable iff (!porN)
    memWrEn |-> !startExec); // R4

endmodule

// File: tb/bootld_top_tb_top.sv
module bootld_top_tb_top;

  localparam int NBYTES = 2048;
  localparam int AW     = 11;

  logic          clk = 1'b0;
  logic          porN = 1'b0;
  logic          wakeIn = 1'b1;
  logic          rxValid = 1'b0;
  logic [7:0]    rxData = '0;
  logic          memWrEn;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWrData;
  logic          startExec;
  logic [AW-1:0] startAddr;

  int totalChecks = 0;
  int badChecks   = 0;

  int cyc = 0;
  int writeCount = 0;
  int startCount = 0;
  int addrErr = 0;
  int expIdx = 0;
  int lastWrCyc = -10;
  int startCyc = -20;
  int startAddrSeen = -1;
  logic [7:0] shadow [NBYTES];

  bootld_top dut_i (
    .clk(clk), .porN(porN), .wakeIn(wakeIn), .rxValid(rxValid), .rxData(rxData),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .startExec(startExec), .startAddr(startAddr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Write and start monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (memWrEn) begin
      writeCount <= writeCount + 1;
      if (int'(memAddr) != expIdx) addrErr <= addrErr + 1;
      expIdx <= expIdx + 1;
      shadow[memAddr] <= memWrData;
      lastWrCyc <= cyc;
    end
    if (startExec) begin
      startCount <= startCount + 1;
      startCyc <= cyc;
      startAddrSeen <= int'(startAddr);
    end
  end

  initial begin
    #2_000_000;
    badChecks = badChecks + 1;
    totalChecks = totalChecks + 1;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    $display("  test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 37 + seed) ^ (i >> 3));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    totalChecks = totalChecks + 1;
    if (!ok) begin
      badChecks = badChecks + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1'b1;
    rxData  = b;
    tick();
    rxValid = 1'b0;
  endtask

  task automatic clearMon();
    @(negedge clk);
    #1;
    writeCount = 0; startCount = 0; addrErr = 0; expIdx = 0;
    lastWrCyc = -10; startCyc = -20; startAddrSeen = -1;
    tick();
  endtask

  task automatic loadImage(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      sendByte(pat(i, seed));
      if (i % 5 == 4) tick();
    end
  endtask

  task automatic checkImage(input int seed, input string req);
    for (int i = 0; i < NBYTES; i++)
      check(shadow[i] == pat(i, seed), req, $sformatf("sram[%0d]", i),
            int'(shadow[i]), int'(pat(i, seed)));
  endtask

  initial begin
    // R1: reset active, wake already high
    tick(); tick();
    @(negedge clk);
    check(memWrEn == 1'b0, "R1", "memWrEn in reset", int'(memWrEn), 0);
    check(startExec == 1'b0, "R1", "startExec in reset", int'(startExec), 0);
    #1;
    porN = 1'b1;
    tick();
    @(negedge clk);
    check(memWrEn == 1'b0 && startExec == 1'b0, "R1", "outputs after release",
          int'({memWrEn, startExec}), 0);
    #1;

    // R2/R6: wake high at release is no edge; bytes in standby ignored
    for (int i = 0; i < 6; i++) sendByte(8'hA0 + 8'(i));
    tick();
    check(writeCount == 0, "R2", "writes with wake level high", writeCount, 0);
    wakeIn = 1'b0;
    sendByte(8'h55);
    tick();
    check(writeCount == 0, "R6", "writes in standby", writeCount, 0);

    // R6: byte in same cycle as wake rise is ignored
    wakeIn = 1'b1;
    sendByte(8'h99);
    tick();
    check(writeCount == 0, "R6", "write on wake-rise cycle", writeCount, 0);

    // R3/R4/R5: full image
    loadImage(NBYTES, 5);
    tick(); tick(); tick();
    check(writeCount == NBYTES, "R4", "write count", writeCount, NBYTES);
    check(addrErr == 0, "R3", "address sequence errors", addrErr, 0);
    checkImage(5, "R3");
    check(startCount == 1, "R5", "start pulses", startCount, 1);
    check(startCyc == lastWrCyc + 1, "R5", "start cycle offset",
          startCyc - lastWrCyc, 1);
    check(startAddrSeen == 0, "R5", "start address", startAddrSeen, 0);

    // R6/R7: terminal state ignores bytes and wake edges
    for (int k = 0; k < 3; k++) begin
      wakeIn = 1'b0; tick();
      wakeIn = 1'b1; tick();
      for (int i = 0; i < 4; i++) sendByte(8'h11);
    end
    tick(); tick();
    check(writeCount == NBYTES, "R6", "writes after done", writeCount, NBYTES);
    check(startCount == 1, "R7", "start pulses after done", startCount, 1);

    // R8: reset mid-load
    porN = 1'b0; tick(); porN = 1'b1; tick();
    clearMon();
    wakeIn = 1'b0; tick(); wakeIn = 1'b1; tick();
    loadImage(300, 9);
    tick();
    check(writeCount == 300, "R8", "partial load writes", writeCount, 300);
    rxValid = 1'b1; rxData = 8'h3C;
    porN = 1'b0;
    @(negedge clk);
    check(memWrEn == 1'b0, "R8", "memWrEn during reset with byte", int'(memWrEn), 0);
    #1;
    rxValid = 1'b0;
    tick();
    porN = 1'b1; tick();
    @(negedge clk);
    check(memWrEn == 1'b0 && startExec == 1'b0, "R8", "outputs after re-reset",
          int'({memWrEn, startExec}), 0);
    #1;
    clearMon();
    wakeIn = 1'b0; tick(); wakeIn = 1'b1; tick();
    loadImage(NBYTES, 77);
    tick(); tick(); tick();
    check(addrErr == 0, "R8", "reload starts at base", addrErr, 0);
    check(writeCount == NBYTES, "R4", "reload write count", writeCount, NBYTES);
    checkImage(77, "R8");
    check(startCount == 1, "R5", "reload start pulses", startCount, 1);
    check(startCyc == lastWrCyc + 1, "R5", "reload start offset",
          startCyc - lastWrCyc, 1);

    $display("  test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

endmodule